// File: doc/BRIEF.md
# Multi-channel interrupting tick timer bank

This block holds a bank of independent hardware timers behind one synchronous register port. Each timer has one control word that packs its terminal count, an enable bit and a one-shot select bit, and a read-only register that shows its running count. An enabled timer counts up by one per clock. When the count has reached the terminal count, the timer raises a one-cycle hit. The count then returns to zero. In periodic mode the timer keeps running. In one-shot mode the hardware clears its enable bit.

Software works out the terminal count as (tick rate in MHz × period in µs) − 1, so one period lasts terminal count + 1 cycles. Each hit sets a sticky bit in a shared status register, and software clears those bits by writing ones. An external watchdog event sets one more status bit in the same register. A mask register with the same bit positions decides which status bits reach the interrupt line. The interrupt line is registered.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset, every control word, count, status bit and mask bit reads 0 and irq_o is low.
- R2: Register map, with the defaults of 4 timers and a 32-bit data word. Addresses 0..3 hold the control words of timers 0..3. Addresses 4..7 hold the counts of timers 0..3, which are read-only. Address 8 is status and address 9 is mask. Other addresses read 0.
- R3: Control word layout: bits [29:0] hold the terminal count, bit 31 is enable and bit 30 is one-shot. Reading the word back returns the stored fields, including an enable bit that the hardware has cleared.
- R4: Periodic mode (bit 30 = 0). Take the write of the control word as edge k. The count reads j after edge k+j, for j up to the terminal count. At edge k+tc+1 the count returns to 0 and counting continues, so the period is tc+1 cycles.
- R5: One-shot mode (bit 30 = 1). At the hit, the count returns to 0, the enable bit clears itself and the count then stays at 0.
- R6: Writing enable = 0 to a running timer stops it, and the count holds its value. Writing the control word while the timer is already disabled resets its count to 0.
- R7: A hit of timer i sets status bit i at the same edge that the count wraps. Writing 1 to a status bit clears it. Writing 0 leaves the bit unchanged.
- R8: When a hit and a clear of the same status bit fall in the same cycle, the bit stays set.
- R9: irq_o is high one cycle after (status & mask) is non-zero, and low one cycle after it becomes zero. Mask bit i gates status bit i.
- R10: While wdog_evt_i is high, status bit 4 (bit NUM_TMR) is set. That bit is cleared by writing 1 to it and is gated by mask bit 4.
- R11: Timers run independently. Each one keeps its own count and sets only its own status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W (4) | Register address for read and write |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data, combinational from addr_i |
| wdog_evt_i | input | 1 | Watchdog event; sets the watchdog status bit |
| irq_o | output | 1 | Registered interrupt request |

## Verification
If a timer's count or enable state is wrong, the count register shows it on the next read. A wrong terminal-count compare moves the status bit by whole cycles, so the status checks are placed on the exact edge where the bit must first appear. A status register that loses a hit during a simultaneous clear reads 0 right after that one edge. A mask or interrupt path with the wrong latency puts irq_o high or low one cycle off from the edge the check expects.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
  typedef enum logic {
    MODE_PERIODIC = 1'b0,
    MODE_ONESHOT  = 1'b1
  } tmr_mode_e;

  typedef enum logic [1:0] {
    REG_CTRL,
    REG_CNT,
    REG_STS,
    REG_MSK
  } reg_kind_e;
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
  import timer_bank_pkg::*;
#(
  parameter int unsigned CNT_W = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic [CNT_W-1:0] tc_i,
  input  logic             en_i,
  input  tmr_mode_e        mode_i,
  output logic [CNT_W-1:0] tc_o,
  output logic             en_o,
  output tmr_mode_e        mode_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] tc_q, cnt_q;
  logic             en_q;
  tmr_mode_e        mode_q;
  logic             hit;

  // >= rather than == so that a terminal count lowered while running still wraps
  assign hit = en_q && (cnt_q >= tc_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_q   <= '0;
      en_q   <= 1'b0;
      mode_q <= MODE_PERIODIC;
    end else if (ctrl_we_i) begin
      tc_q   <= tc_i;
      en_q   <= en_i;
      mode_q <= mode_i;
    end else if (hit && mode_q == MODE_ONESHOT) begin
      en_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (ctrl_we_i && !en_q) cnt_q <= '0;
    else if (hit)                cnt_q <= '0;
    else if (en_q)               cnt_q <= cnt_q + 1'b1;
  end

  assign tc_o   = tc_q;
  assign en_o   = en_q;
  assign mode_o = mode_q;
  assign cnt_o  = cnt_q;
  assign hit_o  = hit;

  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> cnt_q == '0); // R4
  AST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !hit) |=> cnt_q == $past(cnt_q) + 1'b1); // R4
  AST_ONESHOT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && mode_q == MODE_ONESHOT && !ctrl_we_i) |=> !en_q); // R5
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !ctrl_we_i) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int unsigned NUM_SRC = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               sts_we_i,
  input  logic               msk_we_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] sts_o,
  output logic [NUM_SRC-1:0] msk_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] sts_q, msk_q, clr;
  logic               irq_q;

  assign clr = sts_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      msk_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~clr) | set_i;  // set wins over clear
      if (msk_we_i) msk_q <= wdata_i;
      irq_q <= |(sts_q & msk_q);
    end
  end

  assign sts_o = sts_q;
  assign msk_o = msk_q;
  assign irq_o = irq_q;

  AST_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((sts_q & $past(set_i)) == $past(set_i))); // R8
  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr != '0) |=> ((sts_q & $past(clr & ~set_i)) == '0)); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts_q & msk_q) == '0) |=> !irq_o); // R9
  AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts_q & msk_q) != '0) |=> irq_o); // R9
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import timer_bank_pkg::*;
#(
  parameter int unsigned NUM_TMR = 4,
  parameter int unsigned CNT_W   = 30,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = $clog2(2 * NUM_TMR + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              wdog_evt_i,
  output logic              irq_o
);
  localparam int unsigned NUM_SRC  = NUM_TMR + 1;
  localparam int unsigned CNT_BASE = NUM_TMR;
  localparam int unsigned STS_ADDR = 2 * NUM_TMR;
  localparam int unsigned MSK_ADDR = 2 * NUM_TMR + 1;
  localparam int unsigned EN_POS   = DATA_W - 1;
  localparam int unsigned MODE_POS = DATA_W - 2;

  logic [CNT_W-1:0]   tc_w  [NUM_TMR];
  logic [CNT_W-1:0]   cnt_w [NUM_TMR];
  logic [NUM_TMR-1:0] en_w, hit_w;
  tmr_mode_e          mode_w [NUM_TMR];
  logic [NUM_SRC-1:0] sts_w, msk_w, set_w;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    tmr_channel #(.CNT_W(CNT_W)) chan_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctrl_we_i (wr_en_i && addr_i == ADDR_W'(i)),
      .tc_i      (wdata_i[CNT_W-1:0]),
      .en_i      (wdata_i[EN_POS]),
      .mode_i    (tmr_mode_e'(wdata_i[MODE_POS])),
      .tc_o      (tc_w[i]),
      .en_o      (en_w[i]),
      .mode_o    (mode_w[i]),
      .cnt_o     (cnt_w[i]),
      .hit_o     (hit_w[i])
    );
  end

  assign set_w = {wdog_evt_i, hit_w};

  tmr_irq_ctrl #(.NUM_SRC(NUM_SRC)) irq_ctrl_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_w),
    .sts_we_i (wr_en_i && addr_i == ADDR_W'(STS_ADDR)),
    .msk_we_i (wr_en_i && addr_i == ADDR_W'(MSK_ADDR)),
    .wdata_i  (wdata_i[NUM_SRC-1:0]),
    .sts_o    (sts_w),
    .msk_o    (msk_w),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (addr_i == ADDR_W'(i)) begin
        rdata_o[CNT_W-1:0] = tc_w[i];
        rdata_o[EN_POS]    = en_w[i];
        rdata_o[MODE_POS]  = mode_w[i];
      end
      if (addr_i == ADDR_W'(CNT_BASE + i)) rdata_o[CNT_W-1:0] = cnt_w[i];
    end
    if (addr_i == ADDR_W'(STS_ADDR)) rdata_o[NUM_SRC-1:0] = sts_w;
    if (addr_i == ADDR_W'(MSK_ADDR)) rdata_o[NUM_SRC-1:0] = msk_w;
  end

  AST_HIT_ONEHOT_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_w[0] |=> sts_w[0]); // R7
endmodule

// File: tb/tick_timer_bank_tb_top.sv
module tick_timer_bank_tb_top;
  localparam int unsigned NT = 4;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          wdog = 1'b0;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tick_timer_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .wdog_evt_i(wdog), .irq_o(irq)
  );

  function automatic logic [DW-1:0] cw(input bit en, input bit one, input int tc);
    return {en, one, 30'(tc)};
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    addr = AW'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    addr = AW'(a);
    #1 d = rdata;
  endtask

  task automatic cleanup();
    for (int i = 0; i < NT; i++) wr(i, '0);
    wr(9, '0);
    wr(8, 32'h1f);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    for (int a = 0; a < 10; a++) begin rd(a, d); chk("R1 reg", d, '0); end
    rd(12, d); chk("R2 unmapped", d, '0);
    chk("R1 irq", {31'b0, irq}, '0);
  endtask

  task automatic t_periodic();
    logic [DW-1:0] d;
    wr(0, cw(1, 0, 5));
    rd(0, d); chk("R3 readback", d, cw(1, 0, 5));
    repeat (3) @(negedge clk);
    rd(4, d); chk("R4 count 3", d, 3);
    repeat (2) @(negedge clk);
    rd(4, d); chk("R4 count at tc", d, 5);
    rd(8, d); chk("R7 no hit yet", d, 0);
    @(negedge clk);
    rd(4, d); chk("R4 wrap", d, 0);
    rd(8, d); chk("R7 hit sets", d, 1);
    repeat (2) @(negedge clk);
    rd(4, d); chk("R4 keeps running", d, 2);
    chk("R9 masked", {31'b0, irq}, 0);
    wr(9, 32'h1);
    chk("R9 irq latency", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R9 irq up", {31'b0, irq}, 1);
    cleanup();
  endtask

  task automatic t_w1c();
    logic [DW-1:0] d;
    wr(2, cw(1, 0, 1));
    repeat (2) @(negedge clk);
    wr(2, cw(0, 0, 1));
    @(negedge clk);
    rd(8, d); chk("R7 set", d, 32'h4);
    wr(8, 32'h0);
    rd(8, d); chk("R7 write 0 no effect", d, 32'h4);
    wr(8, 32'h4);
    rd(8, d); chk("R7 write 1 clears", d, 32'h0);
    cleanup();
  endtask

  task automatic t_oneshot();
    logic [DW-1:0] d;
    wr(1, cw(1, 1, 3));
    repeat (4) @(negedge clk);
    rd(8, d); chk("R5 hit", d, 32'h2);
    rd(5, d); chk("R5 count zero", d, 0);
    rd(1, d); chk("R5 enable self-clears", d, cw(0, 1, 3));
    wr(8, 32'h2);
    repeat (10) @(negedge clk);
    rd(5, d); chk("R5 stays stopped", d, 0);
    rd(8, d); chk("R5 no further hit", d, 0);
    cleanup();
  endtask

  task automatic t_disable();
    logic [DW-1:0] d;
    wr(2, cw(1, 0, 100));
    repeat (10) @(negedge clk);
    wr(2, cw(0, 0, 100));
    repeat (5) @(negedge clk);
    rd(6, d); chk("R6 holds", d, 11);
    wr(2, cw(0, 0, 100));
    rd(6, d); chk("R6 rewrite resets", d, 0);
    cleanup();
  endtask

  task automatic t_collide();
    logic [DW-1:0] d;
    wr(3, cw(1, 0, 4));
    repeat (4) @(negedge clk);
    wr(8, 32'h8);
    rd(8, d); chk("R8 set wins", d, 32'h8);
    rd(7, d); chk("R8 wrapped", d, 0);
    cleanup();
  endtask

  task automatic t_wdog();
    logic [DW-1:0] d;
    wdog = 1'b1;
    @(negedge clk);
    wdog = 1'b0;
    rd(8, d); chk("R10 status", d, 32'h10);
    chk("R10 masked", {31'b0, irq}, 0);
    wr(9, 32'h10);
    @(negedge clk);
    chk("R10 irq", {31'b0, irq}, 1);
    wr(8, 32'h10);
    rd(8, d); chk("R10 cleared", d, 0);
    @(negedge clk);
    chk("R9 irq drops", {31'b0, irq}, 0);
    cleanup();
  endtask

  task automatic t_indep();
    logic [DW-1:0] d;
    wr(0, cw(1, 0, 2));
    wr(3, cw(1, 0, 6));
    repeat (2) @(negedge clk);
    rd(8, d); chk("R11 own bit only", d, 32'h1);
    rd(4, d); chk("R11 count0", d, 0);
    rd(7, d); chk("R11 count3", d, 2);
    cleanup();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_periodic();
    t_w1c();
    t_oneshot();
    t_disable();
    t_collide();
    t_wdog();
    t_indep();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule